// File: doc/BRIEF.md
# Flash Command and Status Interface

This block is the command front end and status register of a parallel NOR-style flash controller. Bus writes (chip-enable and write-enable both low) deliver command bytes. The block decodes them into start, suspend, resume and clear actions for an internal write/erase engine. That engine stays outside the block and reports back through a busy level and one-cycle failure pulses. The block also holds the read-mode selection, which decides whether a read returns array data or the status byte.

The status byte combines the engine's ready level with an erase-suspended flag and three sticky error flags: erase failure, program failure and supply-low abort. The byte placed on the bus is a snapshot. It is taken when a read cycle opens, which is when the later of chip-enable and output-enable falls. It does not change until one of those enables is released and asserted again. The data bus runs 16 bits wide or 8 bits wide, chosen by an input. In 8-bit mode the top data lane serves as the lowest address input.

All pins are sampled on the rising edge of `clk`. A write takes effect at the first edge where write-enable is seen high again. A read drives the bus from the edge after the read opens.

Top module: `flash_cmd_status`

## Requirements
- R1: The status byte has bit 7 = ready (1 when the engine is idle), bit 6 = erase suspended, bit 5 = erase error, bit 4 = program error, bit 3 = supply-low abort, and bits 2..0 always 0.
- R2: After reset, reads return array data. Command 0x70 makes every later read return status. Command 0xFF returns reads to array data. In array mode the bus carries `array_rd` (its low byte only in 8-bit mode).
- R3: Command 0x40 followed by any data write, or command 0x20 followed by 0xD0, pulses `eng_start_prog` or `eng_start_erase` for one cycle and switches reads to status. A byte other than 0xD0 after 0x20 cancels the erase and starts nothing.
- R4: The status snapshot is taken when the later of `ce_n` and `oe_n` falls, and it stays stable while both remain low.
- R5: While both enables stay low, engine changes are not shown. Only a release and re-assertion of an enable gives a fresh value.
- R6: Command 0xB0, written while an erase is busy, pulses `eng_suspend` and makes status bits 7 and 6 both read 1. Bit 6 stays 1 until command 0xD0 clears it, and that command also pulses `eng_resume`.
- R7: `supply_ok` is sampled only when a program or erase sequence completes. If it is low then, bit 3 is set and no start pulse is issued. `supply_ok` has no effect at any other time.
- R8: In 16-bit mode (`bus_x16`=1), a status read drives all 16 lanes with 0x00 on the upper byte. In 8-bit mode, only lanes 7..0 are driven and `addr_lsb` follows `dq_in[15]`. In 16-bit mode `addr_lsb` is 0.
- R9: Bits 5, 4 and 3 are sticky once set, and only command 0x50 clears them.
- R10: While `eng_busy` is 1 and the engine is not suspended, status bit 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| bus_x16 | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| dq_in | input | 16 | Data bus input (command or data write) |
| array_rd | input | 16 | Array data presented in array-read mode |
| eng_busy | input | 1 | Engine busy level |
| eng_prog_fail | input | 1 | One-cycle pulse: program failed |
| eng_erase_fail | input | 1 | One-cycle pulse: erase failed |
| supply_ok | input | 1 | Programming supply present |
| dq_out | output | 16 | Data bus output value |
| dq_oe | output | 16 | Per-lane output drive enable |
| addr_lsb | output | 1 | Lowest address bit taken from lane 15 in 8-bit mode |
| eng_start_prog | output | 1 | One-cycle program start |
| eng_start_erase | output | 1 | One-cycle erase start |
| eng_suspend | output | 1 | One-cycle erase-suspend request |
| eng_resume | output | 1 | One-cycle erase-resume request |

## Verification
The status read is tried in several ways. It is read while the engine is busy, and it is held open across a busy-to-ready change, which tells a snapshot apart from a live view. It is opened with chip-enable first and output-enable later, which tells "later edge" apart from "first edge". Program and erase sequences run with the supply present and with it absent, so a real start is told apart from an abort. Suspend and resume are interleaved with array-mode reads. Both bus widths are read, so lane driving and the address-lane role can be told apart.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
   localparam logic [7:0] CMD_RD_STATUS = 8'h70;
   localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;
   localparam logic [7:0] CMD_CLR_ERR   = 8'h50;
   localparam logic [7:0] CMD_SUSPEND   = 8'hB0;
   localparam logic [7:0] CMD_CONFIRM   = 8'hD0;
   localparam logic [7:0] CMD_PROG_SET  = 8'h40;
   localparam logic [7:0] CMD_ERASE_SET = 8'h20;

   typedef enum logic [1:0] {SEQ_IDLE, SEQ_PROG, SEQ_ERASE} fcs_seq_e;

   typedef struct packed {
      logic clr;
      logic susp;
      logic resume;
      logic go_prog;
      logic go_erase;
      logic abort;
   } fcs_evt_t;
endpackage

// File: rtl/fcs_cmd_decode.sv
module fcs_cmd_decode
   import fcs_pkg::*;
#(
   parameter int BUS_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce_n,
   input  logic             we_n,
   input  logic [BUS_W-1:0] dq_in,
   input  logic             supply_ok,
   input  logic             eng_busy,
   input  logic             erase_op,
   input  logic             suspended,
   output fcs_evt_t         evt,
   output logic             rd_status,
   output logic             start_prog_q,
   output logic             start_erase_q,
   output logic             suspend_q,
   output logic             resume_q
);
   logic       wr_act, wr_q, wr_evt;
   logic [7:0] cmd;
   fcs_seq_e   seq_q, seq_n;
   logic       mode_n;

   assign wr_act = ~ce_n & ~we_n;
   assign wr_evt = wr_q & ~wr_act;
   assign cmd    = dq_in[7:0];

   always_comb begin
      evt    = '0;
      seq_n  = seq_q;
      mode_n = rd_status;
      if (wr_evt) begin
         unique case (seq_q)
            SEQ_PROG: begin
               seq_n = SEQ_IDLE;
               if (supply_ok) evt.go_prog = 1'b1;
               else           evt.abort   = 1'b1;
            end
            SEQ_ERASE: begin
               seq_n = SEQ_IDLE;
               if (cmd == CMD_CONFIRM) begin
                  if (supply_ok) evt.go_erase = 1'b1;
                  else           evt.abort    = 1'b1;
               end
            end
            default: begin
               unique case (cmd)
                  CMD_PROG_SET:  seq_n  = SEQ_PROG;
                  CMD_ERASE_SET: seq_n  = SEQ_ERASE;
                  CMD_CLR_ERR:   evt.clr = 1'b1;
                  CMD_SUSPEND:   evt.susp = eng_busy & erase_op & ~suspended;
                  CMD_CONFIRM:   evt.resume = suspended;
                  CMD_RD_STATUS: mode_n = 1'b1;
                  CMD_RD_ARRAY:  mode_n = 1'b0;
                  default:       ;
               endcase
            end
         endcase
         if (evt.go_prog || evt.go_erase || evt.abort) mode_n = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q          <= 1'b0;
         seq_q         <= SEQ_IDLE;
         rd_status     <= 1'b0;
         start_prog_q  <= 1'b0;
         start_erase_q <= 1'b0;
         suspend_q     <= 1'b0;
         resume_q      <= 1'b0;
      end else begin
         wr_q          <= wr_act;
         seq_q         <= seq_n;
         rd_status     <= mode_n;
         start_prog_q  <= evt.go_prog;
         start_erase_q <= evt.go_erase;
         suspend_q     <= evt.susp;
         resume_q      <= evt.resume;
      end
   end

   AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
      start_prog_q |-> !start_erase_q) else $error("two starts at once"); // R3
endmodule

// File: rtl/fcs_status.sv
module fcs_status
   import fcs_pkg::*;
#(
   parameter int STAT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  fcs_evt_t          evt,
   input  logic              eng_busy,
   input  logic              eng_prog_fail,
   input  logic              eng_erase_fail,
   input  logic              rd_act,
   input  logic              rd_status,
   output logic              rd_q,
   output logic              suspended,
   output logic              erase_op,
   output logic [STAT_W-1:0] snap
);
   localparam int RSV_W = STAT_W - 5;

   logic              err_erase, err_prog, err_vpp;
   logic [STAT_W-1:0] live;
   logic              rd_open;

   assign live    = {~eng_busy | suspended, suspended, err_erase, err_prog,
                     err_vpp, {RSV_W{1'b0}}};
   assign rd_open = rd_act & ~rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q      <= 1'b0;
         suspended <= 1'b0;
         erase_op  <= 1'b0;
         err_erase <= 1'b0;
         err_prog  <= 1'b0;
         err_vpp   <= 1'b0;
         snap      <= '0;
      end else begin
         rd_q <= rd_act;
         if (rd_open && rd_status) snap <= live;
         if (evt.susp)        suspended <= 1'b1;
         else if (evt.resume) suspended <= 1'b0;
         if (evt.go_erase)     erase_op <= 1'b1;
         else if (evt.go_prog) erase_op <= 1'b0;
         if (evt.clr) begin
            err_erase <= 1'b0;
            err_prog  <= 1'b0;
            err_vpp   <= 1'b0;
         end else begin
            if (eng_erase_fail) err_erase <= 1'b1;
            if (eng_prog_fail)  err_prog  <= 1'b1;
            if (evt.abort)      err_vpp   <= 1'b1;
         end
      end
   end

   AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_q && rd_act) |=> $stable(snap)) else $error("snapshot moved"); // R4
   AST_SUSP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (suspended && rd_open && rd_status) |=> (snap[STAT_W-1] && snap[STAT_W-2]))
      else $error("suspend flags"); // R6
   AST_VPP_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_vpp) |-> $past(evt.abort)) else $error("vpp outside seq"); // R7
   AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      evt.clr |=> !(err_erase || err_prog || err_vpp)) else $error("clear"); // R9
endmodule

// File: rtl/fcs_bus_fmt.sv
module fcs_bus_fmt #(
   parameter int BUS_W  = 16,
   parameter int STAT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_x16,
   input  logic              rd_q,
   input  logic              rd_status,
   input  logic [STAT_W-1:0] snap,
   input  logic [BUS_W-1:0]  array_rd,
   input  logic [BUS_W-1:0]  dq_in,
   output logic [BUS_W-1:0]  dq_out,
   output logic [BUS_W-1:0]  dq_oe,
   output logic              addr_lsb
);
   for (genvar g = 0; g < BUS_W; g++) begin : g_lane
      if (g < STAT_W) begin : g_low
         assign dq_oe[g]  = rd_q;
         assign dq_out[g] = rd_q & (rd_status ? snap[g] : array_rd[g]);
      end else begin : g_high
         assign dq_oe[g]  = rd_q & bus_x16;
         assign dq_out[g] = rd_q & bus_x16 & ~rd_status & array_rd[g];
      end
   end

   assign addr_lsb = ~bus_x16 & dq_in[BUS_W-1];

   AST_X8_UPPER_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_x16 |-> (dq_oe[BUS_W-1:STAT_W] == '0)) else $error("x8 lanes"); // R8
endmodule

// File: rtl/flash_cmd_status.sv
module flash_cmd_status
   import fcs_pkg::*;
#(
   parameter int BUS_W  = 16,
   parameter int STAT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce_n,
   input  logic             oe_n,
   input  logic             we_n,
   input  logic             bus_x16,
   input  logic [BUS_W-1:0] dq_in,
   input  logic [BUS_W-1:0] array_rd,
   input  logic             eng_busy,
   input  logic             eng_prog_fail,
   input  logic             eng_erase_fail,
   input  logic             supply_ok,
   output logic [BUS_W-1:0] dq_out,
   output logic [BUS_W-1:0] dq_oe,
   output logic             addr_lsb,
   output logic             eng_start_prog,
   output logic             eng_start_erase,
   output logic             eng_suspend,
   output logic             eng_resume
);
   if (STAT_W != 8) begin : g_bad_stat
      $error("STAT_W must be 8");
   end
   if (BUS_W != 2 * STAT_W) begin : g_bad_bus
      $error("BUS_W must be twice STAT_W");
   end

   fcs_evt_t          evt;
   logic              rd_status, rd_q, suspended, erase_op, rd_act;
   logic [STAT_W-1:0] snap;

   assign rd_act = ~ce_n & ~oe_n;

   fcs_cmd_decode #(.BUS_W(BUS_W)) i_dec (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .dq_in(dq_in),
      .supply_ok(supply_ok), .eng_busy(eng_busy), .erase_op(erase_op),
      .suspended(suspended), .evt(evt), .rd_status(rd_status),
      .start_prog_q(eng_start_prog), .start_erase_q(eng_start_erase),
      .suspend_q(eng_suspend), .resume_q(eng_resume));

   fcs_status #(.STAT_W(STAT_W)) i_stat (
      .clk(clk), .rst_n(rst_n), .evt(evt), .eng_busy(eng_busy),
      .eng_prog_fail(eng_prog_fail), .eng_erase_fail(eng_erase_fail),
      .rd_act(rd_act), .rd_status(rd_status), .rd_q(rd_q),
      .suspended(suspended), .erase_op(erase_op), .snap(snap));

   fcs_bus_fmt #(.BUS_W(BUS_W), .STAT_W(STAT_W)) i_fmt (
      .clk(clk), .rst_n(rst_n), .bus_x16(bus_x16), .rd_q(rd_q),
      .rd_status(rd_status), .snap(snap), .array_rd(array_rd), .dq_in(dq_in),
      .dq_out(dq_out), .dq_oe(dq_oe), .addr_lsb(addr_lsb));

   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_busy && !suspended && rd_act && !rd_q && rd_status) |=> !dq_out[STAT_W-1])
      else $error("busy shows ready"); // R10
endmodule

// File: tb/test_flash_cmd_status.sv
module test_flash_cmd_status;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, bus_x16 = 1'b1;
   logic [15:0] dq_in = '0, array_rd = 16'hA5C3;
   logic        eng_busy = 1'b0, eng_prog_fail = 1'b0, eng_erase_fail = 1'b0;
   logic        supply_ok = 1'b1;
   logic [15:0] dq_out, dq_oe;
   logic        addr_lsb, eng_start_prog, eng_start_erase, eng_suspend, eng_resume;

   int n_chk = 0, n_bad = 0;
   int n_prog = 0, n_erase = 0, n_susp = 0, n_res = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   flash_cmd_status i_flash_cmd_status (.*);

   always @(negedge clk) begin
      if (eng_start_prog)  n_prog++;
      if (eng_start_erase) n_erase++;
      if (eng_suspend)     n_susp++;
      if (eng_resume)      n_res++;
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic write_bus(input logic [15:0] v);
      @(negedge clk); ce_n = 1'b0; we_n = 1'b0; dq_in = v;
      @(negedge clk);
      @(negedge clk); we_n = 1'b1;
      @(negedge clk); ce_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic read_open();
      @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
      @(negedge clk); @(negedge clk);
   endtask

   task automatic read_close();
      @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic read_check(input string tag, input logic [15:0] exp_d, input logic [15:0] exp_oe);
      read_open();
      check({tag, " data"}, dq_out, exp_d);
      check({tag, " oe"}, dq_oe, exp_oe);
      read_close();
   endtask

   task automatic t_reset();
      check("R2 reset idle oe", dq_oe, 16'h0000);
      read_check("R2 array after reset", 16'hA5C3, 16'hFFFF);
      write_bus(16'h0070);
      read_check("R1 R8 idle status x16", 16'h0080, 16'hFFFF);
      write_bus(16'h00FF);
      read_check("R2 back to array", 16'hA5C3, 16'hFFFF);
   endtask

   task automatic t_program_hold();
      int p0 = n_prog;
      write_bus(16'h0040);
      write_bus(16'h1234);
      check("R3 program start pulse", n_prog - p0, 1);
      eng_busy = 1'b1;
      read_open();
      check("R10 busy bit7 low", dq_out, 16'h0000);
      eng_busy = 1'b0;
      repeat (4) @(negedge clk);
      check("R5 held read stays old", dq_out, 16'h0000);
      oe_n = 1'b1; @(negedge clk);
      oe_n = 1'b0; @(negedge clk); @(negedge clk);
      check("R5 toggled read shows ready", dq_out, 16'h0080);
      read_close();
      eng_busy = 1'b1;
      @(negedge clk); ce_n = 1'b0;
      @(negedge clk); eng_busy = 1'b0;
      @(negedge clk); oe_n = 1'b0;
      @(negedge clk); @(negedge clk);
      check("R4 later edge captures", dq_out, 16'h0080);
      read_close();
   endtask

   task automatic t_errors();
      write_bus(16'h0040);
      write_bus(16'h5555);
      eng_busy = 1'b1;
      @(negedge clk); eng_prog_fail = 1'b1;
      @(negedge clk); eng_prog_fail = 1'b0; eng_busy = 1'b0;
      read_check("R1 program error bit4", 16'h0090, 16'hFFFF);
      write_bus(16'h0070);
      read_check("R9 error sticky", 16'h0090, 16'hFFFF);
      @(negedge clk); eng_erase_fail = 1'b1;
      @(negedge clk); eng_erase_fail = 1'b0;
      read_check("R1 erase error bit5", 16'h00B0, 16'hFFFF);
      write_bus(16'h0050);
      read_check("R9 clear errors", 16'h0080, 16'hFFFF);
   endtask

   task automatic t_supply();
      int e0 = n_erase;
      supply_ok = 1'b0;
      read_check("R7 supply low no sequence", 16'h0080, 16'hFFFF);
      write_bus(16'h0020);
      write_bus(16'h00D0);
      check("R7 no erase start on abort", n_erase - e0, 0);
      read_check("R7 abort bit3", 16'h0088, 16'hFFFF);
      write_bus(16'h0050);
      read_check("R7 stays clear while low", 16'h0080, 16'hFFFF);
      supply_ok = 1'b1;
      write_bus(16'h0020);
      write_bus(16'h0011);
      check("R3 erase cancelled", n_erase - e0, 0);
   endtask

   task automatic t_suspend();
      int e0 = n_erase, s0 = n_susp, r0 = n_res;
      write_bus(16'h0020);
      write_bus(16'h00D0);
      check("R3 erase start pulse", n_erase - e0, 1);
      eng_busy = 1'b1;
      read_check("R10 erase busy", 16'h0000, 16'hFFFF);
      write_bus(16'h00B0);
      check("R6 suspend pulse", n_susp - s0, 1);
      read_check("R6 ready and suspended", 16'h00C0, 16'hFFFF);
      write_bus(16'h00FF);
      read_check("R2 array while suspended", 16'hA5C3, 16'hFFFF);
      write_bus(16'h0070);
      read_check("R6 suspended persists", 16'h00C0, 16'hFFFF);
      write_bus(16'h00D0);
      check("R6 resume pulse", n_res - r0, 1);
      read_check("R6 resumed busy", 16'h0000, 16'hFFFF);
      eng_busy = 1'b0;
      read_check("R6 resumed done", 16'h0080, 16'hFFFF);
   endtask

   task automatic t_x8();
      bus_x16 = 1'b0;
      read_check("R8 x8 status", 16'h0080, 16'h00FF);
      @(negedge clk); dq_in = 16'h8000;
      @(negedge clk);
      check("R8 x8 addr lane", addr_lsb, 1'b1);
      write_bus(16'h00FF);
      read_check("R8 x8 array", 16'h00C3, 16'h00FF);
      bus_x16 = 1'b1;
      @(negedge clk); dq_in = 16'h8000;
      @(negedge clk);
      check("R8 x16 addr lane off", addr_lsb, 1'b0);
      read_check("R8 x16 array", 16'hA5C3, 16'hFFFF);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_program_hold();
      t_errors();
      t_supply();
      t_suspend();
      t_x8();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule